// File: doc/BRIEF.md
# Active Interrupt Number Resolver

This block sits beside a banked interrupt controller. It turns the controller's masked pending state into a single interrupt number so that an interrupt handler can learn which source to serve in one register read, with no software bit search. The controller keeps its state in three vectors. A 21-bit summary vector holds eight direct lines, two "bank has something pending" flags, and eleven shortcut copies of selected bank bits. Two 32-bit vectors hold the full pending state of bank one and bank two.

The resolver applies a fixed priority that is deliberately not a flat lowest-index scan. Direct lines come first. Shortcut copies come next, in a fixed order. After those, each bank is scanned in full, but only if its flag is set, and bits that already have a shortcut copy are skipped during the scan. The result is registered, so the number and its valid flag appear one clock after the pending state is presented. When nothing qualifies, valid is low and the number reads zero.

Top module: `int_num_resolver`

## Requirements
- R1: Numbering: summary bit n (n = 0..7) is number n, bank-one bit n is 8+n, and bank-two bit n is 40+n. Every valid output is below 72.
- R2: The output is registered. A new pending state is reflected one clock edge later, and the previous result holds until that edge. While reset is active the output is invalid with number 0.
- R3: When all 21 summary bits are zero, the output is invalid, whatever the bank vectors hold.
- R4: If any of summary bits 7:0 is set, the lowest set one among them is the result, ahead of every other source.
- R5: Otherwise summary bits 10..14 are checked in that order and stand for bank-one bits 7, 9, 10, 18, 19 (numbers 15, 17, 18, 26, 27). They rank above all bank-two shortcuts and both bank scans.
- R6: Otherwise summary bits 15..20 are checked in that order and stand for bank-two bits 21, 22, 23, 24, 25, 30 (numbers 61..65, 70). They rank above both bank scans.
- R7: Otherwise, if summary bit 8 is set, the lowest set bank-one bit other than 7, 9, 10, 18, 19 is the result. A bank-one bit is never chosen while bit 8 is clear.
- R8: Otherwise, if summary bit 9 is set, the lowest set bank-two bit other than 21..25 and 30 is the result. A bank-two bit is never chosen while bit 9 is clear.
- R9: When the summary is non-zero but none of the steps above finds a bit (for example, flags set with only shortcut-covered bank bits pending), the output is invalid.
- R10: Whenever valid is low, the number output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sum_pend_i | input | 21 | Summary pending vector: lines 7:0, bank flags 8 and 9, shortcuts 20:10 |
| bank1_pend_i | input | 32 | Bank-one pending vector |
| bank2_pend_i | input | 32 | Bank-two pending vector |
| irq_num_o | output | 7 | Resolved interrupt number, 0 when invalid |
| irq_valid_o | output | 1 | High when irq_num_o names a pending source |

## Verification
Every result is due exactly one rising edge after its pending vectors are driven. The driver applies vectors on falling edges and pushes the expected number and valid pair into a queue. The monitor pops one entry a short time after each rising edge, so each vector is compared at the first point where it can be visible. One dedicated check samples just after a new vector is driven and before the next rising edge, to confirm that the previous result still holds.

// File: rtl/intres_pkg.sv
package intres_pkg;

    localparam int LINE_N     = 8;
    localparam int BANK_W     = 32;
    localparam int NUM_W      = 7;
    localparam int SC1_N      = 5;
    localparam int SC2_N      = 6;
    localparam int FLAG1_POS  = LINE_N;
    localparam int FLAG2_POS  = LINE_N + 1;
    localparam int SC_LO      = LINE_N + 2;
    localparam int SC_N       = SC1_N + SC2_N;
    localparam int SUM_W      = SC_LO + SC_N;
    localparam int BANK1_BASE = LINE_N;
    localparam int BANK2_BASE = LINE_N + BANK_W;

    // Bank bit carried by shortcut k; k < SC1_N belongs to bank one.
    function automatic int sc_bit(input int k);
        case (k)
            0:       return 7;
            1:       return 9;
            2:       return 10;
            3:       return 18;
            4:       return 19;
            5:       return 21;
            6:       return 22;
            7:       return 23;
            8:       return 24;
            9:       return 25;
            default: return 30;
        endcase
    endfunction

    // Bank bits that have a shortcut copy and are skipped by the full scan.
    function automatic logic [BANK_W-1:0] sc_mask(input bit second);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int k = 0; k < SC_N; k++) begin
            if ((k >= SC1_N) == second) m[sc_bit(k)] = 1'b1;
        end
        return m;
    endfunction

    typedef struct packed {
        logic             valid;
        logic [NUM_W-1:0] num;
    } res_t;

endpackage

// File: rtl/lsb_finder.sv
module lsb_finder #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
        found_o = |vec_i;
    end
endmodule

// File: rtl/bank_scan.sv
module bank_scan
    import intres_pkg::*;
#(
    parameter int BASE   = BANK1_BASE,
    parameter bit SECOND = 1'b0
) (
    input  logic              flag_i,
    input  logic [BANK_W-1:0] pend_i,
    output logic              hit_o,
    output logic [NUM_W-1:0]  num_o
);
    localparam int IW = $clog2(BANK_W);
    localparam logic [BANK_W-1:0] SKIP = sc_mask(SECOND);

    logic [BANK_W-1:0] eligible;
    logic              found;
    logic [IW-1:0]     idx;

    assign eligible = pend_i & ~SKIP;

    lsb_finder #(.W(BANK_W)) find_i (
        .vec_i   (eligible),
        .found_o (found),
        .idx_o   (idx)
    );

    assign hit_o = flag_i & found;
    assign num_o = NUM_W'(BASE) + NUM_W'(idx);
endmodule

// File: rtl/int_num_resolver.sv
module int_num_resolver
    import intres_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SUM_W-1:0]  sum_pend_i,
    input  logic [BANK_W-1:0] bank1_pend_i,
    input  logic [BANK_W-1:0] bank2_pend_i,
    output logic [NUM_W-1:0]  irq_num_o,
    output logic              irq_valid_o
);
    localparam int LIW = (LINE_N > 1) ? $clog2(LINE_N) : 1;
    localparam int SIW = (SC_N > 1) ? $clog2(SC_N) : 1;

    logic             line_found, sc_found, b1_hit, b2_hit;
    logic [LIW-1:0]   line_idx;
    logic [SIW-1:0]   sc_idx;
    logic [NUM_W-1:0] b1_num, b2_num;
    res_t             st_d, st_q;

    lsb_finder #(.W(LINE_N)) line_find_i (
        .vec_i   (sum_pend_i[LINE_N-1:0]),
        .found_o (line_found),
        .idx_o   (line_idx)
    );

    // Shortcut bits are ordered by priority, so the lowest set one wins.
    lsb_finder #(.W(SC_N)) sc_find_i (
        .vec_i   (sum_pend_i[SUM_W-1:SC_LO]),
        .found_o (sc_found),
        .idx_o   (sc_idx)
    );

    bank_scan #(.BASE(BANK1_BASE), .SECOND(1'b0)) scan1_i (
        .flag_i (sum_pend_i[FLAG1_POS]),
        .pend_i (bank1_pend_i),
        .hit_o  (b1_hit),
        .num_o  (b1_num)
    );

    bank_scan #(.BASE(BANK2_BASE), .SECOND(1'b1)) scan2_i (
        .flag_i (sum_pend_i[FLAG2_POS]),
        .pend_i (bank2_pend_i),
        .hit_o  (b2_hit),
        .num_o  (b2_num)
    );

    always_comb begin
        st_d = '0;
        if (line_found) begin
            st_d.valid = 1'b1;
            st_d.num   = NUM_W'(line_idx);
        end else if (sc_found) begin
            st_d.valid = 1'b1;
            if (int'(sc_idx) < SC1_N)
                st_d.num = NUM_W'(BANK1_BASE + sc_bit(int'(sc_idx)));
            else
                st_d.num = NUM_W'(BANK2_BASE + sc_bit(int'(sc_idx)));
        end else if (b1_hit) begin
            st_d.valid = 1'b1;
            st_d.num   = b1_num;
        end else if (b2_hit) begin
            st_d.valid = 1'b1;
            st_d.num   = b2_num;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_num_o   = st_q.num;
    assign irq_valid_o = st_q.valid;
endmodule

// File: rtl/intres_chk.sv
module intres_chk
    import intres_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [SUM_W-1:0]  sum_pend_i,
    input logic [BANK_W-1:0] bank1_pend_i,
    input logic [BANK_W-1:0] bank2_pend_i,
    input logic [NUM_W-1:0]  irq_num_o,
    input logic              irq_valid_o
);
    localparam logic [BANK_W-1:0] M1 = sc_mask(1'b0);
    localparam logic [BANK_W-1:0] M2 = sc_mask(1'b1);

    logic no_line, no_sc1, no_sc2;
    assign no_line = (sum_pend_i[LINE_N-1:0] == '0);
    assign no_sc1  = (sum_pend_i[SC_LO+SC1_N-1:SC_LO] == '0);
    assign no_sc2  = (sum_pend_i[SUM_W-1:SC_LO+SC1_N] == '0);

    assert_num_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_valid_o |-> (irq_num_o < 7'd72));

    assert_empty_invalid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sum_pend_i == '0) |=> !irq_valid_o);

    assert_line_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !no_line |=> (irq_valid_o && irq_num_o < 7'(LINE_N)));

    assert_sc1_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (no_line && !no_sc1) |=> (irq_valid_o && (irq_num_o == 7'd15 ||
            irq_num_o == 7'd17 || irq_num_o == 7'd18 || irq_num_o == 7'd26 ||
            irq_num_o == 7'd27)));

    assert_sc2_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (no_line && no_sc1 && !no_sc2) |=> (irq_valid_o &&
            irq_num_o >= 7'd61 && irq_num_o <= 7'd70));

    assert_nothing_left_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (no_line && no_sc1 && no_sc2 &&
         !(sum_pend_i[FLAG1_POS] && |(bank1_pend_i & ~M1)) &&
         !(sum_pend_i[FLAG2_POS] && |(bank2_pend_i & ~M2))) |=> !irq_valid_o);

    assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_valid_o |-> (irq_num_o == '0));
endmodule

bind int_num_resolver intres_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sum_pend_i   (sum_pend_i),
    .bank1_pend_i (bank1_pend_i),
    .bank2_pend_i (bank2_pend_i),
    .irq_num_o    (irq_num_o),
    .irq_valid_o  (irq_valid_o)
);

// File: tb/int_num_resolver_tb_top.sv
module int_num_resolver_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] sum_pend = '0;
    logic [31:0] b1_pend = '0;
    logic [31:0] b2_pend = '0;
    logic [6:0]  num;
    logic        valid;

    int total = 0;
    int bad   = 0;

    int    q_num[$];
    bit    q_val[$];
    string q_tag[$];

    always #2 clk = ~clk;

    int_num_resolver dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sum_pend_i   (sum_pend),
        .bank1_pend_i (b1_pend),
        .bank2_pend_i (b2_pend),
        .irq_num_o    (num),
        .irq_valid_o  (valid)
    );

    // Reference ordering written from the requirements.
    task automatic model(input logic [20:0] s, input logic [31:0] x1,
                         input logic [31:0] x2, output bit v, output int n);
        int s1[5] = '{7, 9, 10, 18, 19};
        int s2[6] = '{21, 22, 23, 24, 25, 30};
        bit skip;
        v = 1'b0;
        n = 0;
        if (s == '0) return;
        for (int i = 0; i < 8; i++) if (s[i]) begin v = 1; n = i; return; end
        for (int j = 0; j < 5; j++) if (s[10+j]) begin v = 1; n = 8 + s1[j]; return; end
        for (int j = 0; j < 6; j++) if (s[15+j]) begin v = 1; n = 40 + s2[j]; return; end
        if (s[8]) for (int b = 0; b < 32; b++) begin
            skip = 0;
            foreach (s1[k]) if (s1[k] == b) skip = 1;
            if (x1[b] && !skip) begin v = 1; n = 8 + b; return; end
        end
        if (s[9]) for (int b = 0; b < 32; b++) begin
            skip = 0;
            foreach (s2[k]) if (s2[k] == b) skip = 1;
            if (x2[b] && !skip) begin v = 1; n = 40 + b; return; end
        end
    endtask

    task automatic check(input string tag, input bit ev, input int en);
        total++;
        if (valid !== ev || int'(num) != en) begin
            bad++;
            $display("FAIL %s: got valid=%0d num=%0d, expected valid=%0d num=%0d",
                     tag, valid, num, ev, en);
        end
    endtask

    task automatic drive(input logic [20:0] s, input logic [31:0] x1,
                         input logic [31:0] x2, input string tag);
        bit v;
        int n;
        @(negedge clk);
        sum_pend = s;
        b1_pend  = x1;
        b2_pend  = x2;
        model(s, x1, x2, v, n);
        q_val.push_back(v);
        q_num.push_back(n);
        q_tag.push_back(tag);
    endtask

    // Monitor: each result is due one rising edge after its drive (R2).
    initial forever begin
        @(posedge clk);
        #1;
        if (q_val.size() > 0) check(q_tag.pop_front(), q_val.pop_front(), q_num.pop_front());
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] a, b, c;
        a = 32'h1234_5678; b = 32'h9ABC_DEF1; c = 32'h0F0F_3C3C;
        sum_pend = 21'h1FFFFF;
        repeat (3) @(posedge clk);
        #1 check("R2 reset", 1'b0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(21'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 empty summary");
        drive(21'h1FFFFF, '1, '1, "R4 all set");
        drive(21'h000A0, 0, 0, "R4 lowest line");
        drive(21'h00480, 0, 0, "R4 line over shortcut");
        drive(21'h00008, 0, 0, "R1 line 3");
        drive(21'h05000, 0, 0, "R5 bit12 before bit14");
        drive(21'h08400, 0, 0, "R5 bank1 shortcut before bank2");
        drive(21'h02000, 0, 0, "R5 bit13");
        drive(21'h110000, 0, 0, "R6 bit16 first");
        drive(21'h100000, 0, 0, "R6 bit20 alone");
        drive(21'h100100, 32'h1, 0, "R6 shortcut before scan");
        drive(21'h00100, 32'h0000_0880, 0, "R7 skip bit7");
        drive(21'h00300, 32'h8000_0000, 32'h1, "R7 bank1 before bank2");
        drive(21'h00200, 32'h1, 32'h10, "R7 flag clear");
        drive(21'h00100, 32'h1, 0, "R1 bank1 bit0");
        drive(21'h00200, 0, 32'h1, "R1 bank2 bit0");
        drive(21'h00200, 0, 32'h8020_0000, "R8 skip bit21");
        drive(21'h00200, 0, 32'h4400_0000, "R8 skip bit30");
        drive(21'h00300, 32'h000C_0680, 32'h43E0_0000, "R9 only shortcut bits");
        drive(21'h00000, 0, 0, "R10 idle");

        // R2: output holds until the next rising edge.
        drive(21'h00001, 0, 0, "R2 first");
        drive(21'h00020, 0, 0, "R2 second");
        #1 check("R2 hold before edge", 1'b1, 0);

        for (int i = 0; i < 300; i++) begin
            a = {a[30:0], a[31] ^ a[21] ^ a[1] ^ a[0]};
            b = b * 32'd1664525 + 32'd1013904223;
            c = c ^ (c << 13); c = c ^ (c >> 17); c = c ^ (c << 5);
            drive(a[20:0] & b[20:0] & c[20:0] | {11'h0, b[31:30], 8'h0},
                  a & c, b ^ c, "R1 mixed pattern");
        end

        repeat (3) @(posedge clk);
        #1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule